// File: doc/BRIEF.md
# Previous-Word Serial Readout Port

This block sits beside a successive-approximation converter core. It reads out the result of the last finished conversion on a second serial line, clocked by a readout clock that runs faster than the conversion clock. A single active-low latch strobe does two things. It copies the core's parallel result into a readout shift register, and it issues the convert pulse that starts the next conversion. Word n-1 therefore shifts out most significant bit first while the core works on word n. The external convert input of the converter is not used in this mode.

The strobe and the conversion clock arrive asynchronously. Each passes through a two-flop synchronizer into the readout clock domain. The block takes the capture only after the synchronized strobe has stayed low for a minimum number of readout cycles. It also refuses a capture that would come after the conversion clock has already risen, because the core clears its result on that edge. Each of these two faults sets its own sticky error bit.

Top module: `prev_word_readout`

## Requirements
- R1: While rst_ni is low, sdo_o, conv_o and err_o are all 0.
- R2: latch_ni passes through a two-flop synchronizer. The capture happens on the readout edge at which the synchronized strobe has been low for MIN_LOW consecutive samples. If latch_ni is first sampled low at edge e and stays low, the capture is at edge e+MIN_LOW+1, and it records result_i as sampled at that edge.
- R3: conv_o is high for exactly one readout cycle, directly after the capture edge. In that same cycle sdo_o shows the captured bit WIDTH-1.
- R4: After a capture, sdo_o gives the captured word most significant bit first, stepping to the next lower bit on each readout edge.
- R5: Once bit 0 has been shown, sdo_o holds it until the next capture. Before the first capture after reset, sdo_o is 0.
- R6: A change on result_i after the capture edge has no effect on the word being shifted out.
- R7: A strobe whose synchronized low phase lasts fewer than MIN_LOW cycles sets err_o[0] and produces neither a capture nor a conv_o pulse.
- R8: A synchronized rising edge of conv_clk_i that arrives during a strobe's low phase, at or before the cycle that would capture, sets err_o[1]. For that strobe it suppresses both the capture and conv_o. The conversion clock goes through the same two-flop synchronizer as the strobe.
- R9: The err_o bits are sticky. Once set, a bit stays 1 until reset, and later good strobes still capture normally.
- R10: A strobe held low for any length of time at or above MIN_LOW cycles gives exactly one capture and one conv_o pulse.
- R11: A capture that arrives while an earlier word is still shifting restarts the output at bit WIDTH-1 of the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Readout clock; all state is clocked by it |
| rst_ni | input | 1 | Asynchronous active-low reset |
| conv_clk_i | input | 1 | Conversion clock of the core, asynchronous |
| latch_ni | input | 1 | Active-low latch strobe, asynchronous |
| result_i | input | WIDTH | Parallel result of the finished conversion |
| sdo_o | output | 1 | Serial readout data, MSB first |
| conv_o | output | 1 | Internal convert pulse to the core |
| err_o | output | 2 | Sticky errors: bit 0 short strobe, bit 1 late capture |

## Verification
The bench builds the block with WIDTH = 16 and MIN_LOW = 2. With these values a full readout fits inside the 20-cycle conversion frame, so the bench can check both the hold after bit 0 and a restart during an unfinished readout. A strobe of a single cycle falls just below the qualification threshold. The bench can also place a conversion-clock edge inside the three-cycle capture window on purpose, which exercises the late-capture rule. A free-running framed phase with a stub core shows word n-1 leaving the block while result_i already holds a later value.

// File: rtl/readout_pkg.sv
package readout_pkg;
  localparam int unsigned ERR_W     = 2;
  localparam int unsigned ERR_SHORT = 0;
  localparam int unsigned ERR_LATE  = 1;
  typedef logic [ERR_W-1:0] err_vec_t;
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] ff;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff <= {2{RST_VAL[i]}};
      else         ff <= {ff[0], d_i[i]};
    end
    assign q_o[i] = ff[1];
  end
endmodule

// File: rtl/strobe_qual.sv
module strobe_qual
  import readout_pkg::*;
#(
  parameter int unsigned MIN_LOW = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     lat_s_i,
  input  logic     ck_s_i,
  output logic     load_o,
  output err_vec_t err_o
);
  localparam int unsigned CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] LOW_MAX = CW'(MIN_LOW);
  localparam logic [CW-1:0] LOW_HIT = CW'(MIN_LOW - 1);

  logic [CW-1:0] low_cnt;
  logic          late_seen, ck_d;
  logic          ck_rise, late_now, short_now;
  err_vec_t      err_q;

  assign ck_rise   = ck_s_i & ~ck_d;
  // core clears its result on the conversion clock edge: capture would be stale
  assign late_now  = ~lat_s_i & (low_cnt < LOW_MAX) & ck_rise;
  assign load_o    = ~lat_s_i & (low_cnt == LOW_HIT) & ~late_seen & ~late_now;
  assign short_now = lat_s_i & (low_cnt != '0) & (low_cnt < LOW_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck_d      <= 1'b0;
      low_cnt   <= '0;
      late_seen <= 1'b0;
      err_q     <= '0;
    end else begin
      ck_d <= ck_s_i;
      if (lat_s_i) begin
        low_cnt   <= '0;
        late_seen <= 1'b0;
      end else begin
        if (low_cnt != LOW_MAX) low_cnt <= low_cnt + 1'b1;
        if (late_now)           late_seen <= 1'b1;
      end
      if (short_now) err_q[ERR_SHORT] <= 1'b1;
      if (late_now)  err_q[ERR_LATE]  <= 1'b1;
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic         sdo_o
);
  localparam int unsigned CW = $clog2(W);

  logic [W-1:0]  sreg;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg <= '0;
      cnt  <= '0;
    end else if (load_i) begin
      sreg <= data_i;
      cnt  <= CW'(W - 1);
    end else if (cnt != '0) begin
      sreg <= {sreg[W-2:0], 1'b0};
      cnt  <= cnt - 1'b1;
    end
  end

  assign sdo_o = sreg[W-1];
endmodule

// File: rtl/prev_word_readout.sv
module prev_word_readout
  import readout_pkg::*;
#(
  parameter int unsigned WIDTH   = 16,
  parameter int unsigned MIN_LOW = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_clk_i,
  input  logic             latch_ni,
  input  logic [WIDTH-1:0] result_i,
  output logic             sdo_o,
  output logic             conv_o,
  output logic [ERR_W-1:0] err_o
);
  logic     lat_s, ck_s, load;
  logic     conv_q;
  err_vec_t err;

  bit_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({conv_clk_i, latch_ni}),
    .q_o    ({ck_s, lat_s})
  );

  strobe_qual #(.MIN_LOW(MIN_LOW)) u_qual (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lat_s_i (lat_s),
    .ck_s_i  (ck_s),
    .load_o  (load),
    .err_o   (err)
  );

  word_shifter #(.W(WIDTH)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .data_i (result_i),
    .sdo_o  (sdo_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) conv_q <= 1'b0;
    else         conv_q <= load;
  end

  assign conv_o = conv_q;
  assign err_o  = err;
endmodule

// File: rtl/prev_word_readout_chk.sv
module prev_word_readout_chk
  import readout_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             latch_ni,
  input logic             result_msb_i,
  input logic             sdo_o,
  input logic             conv_o,
  input logic [ERR_W-1:0] err_o
);
  p_pulse_one_cycle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |=> !conv_o);

  p_msb_with_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |-> (sdo_o == $past(result_msb_i)));

  p_pulse_needs_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |-> !$past(latch_ni, 3));

  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((err_o & $past(err_o)) == $past(err_o)));

  p_late_no_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o[ERR_LATE]) |-> !conv_o);
endmodule

bind prev_word_readout prev_word_readout_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .latch_ni     (latch_ni),
  .result_msb_i (result_i[WIDTH-1]),
  .sdo_o        (sdo_o),
  .conv_o       (conv_o),
  .err_o        (err_o)
);

// File: tb/sim_prev_word_readout.sv
module sim_prev_word_readout;
  localparam int WID  = 16;
  localparam int MINL = 2;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic           conv_clk_i = 1'b0;
  logic           latch_ni = 1'b1;
  logic [WID-1:0] result_i = '0;
  logic           sdo_o, conv_o;
  logic [1:0]     err_o;

  always #2 clk = ~clk;

  prev_word_readout #(.WIDTH(WID), .MIN_LOW(MINL)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .conv_clk_i(conv_clk_i), .latch_ni(latch_ni),
    .result_i(result_i), .sdo_o(sdo_o), .conv_o(conv_o), .err_o(err_o)
  );

  int    n_vec = 0, n_bad = 0;
  string tag = "R1";

  // behavioural reference
  bit             q_lat[$];
  bit             q_ck[$];
  int             m_low, m_idx;
  bit             m_late, m_conv;
  bit [1:0]       m_err;
  logic [WID-1:0] m_data;
  bit             stub_on = 0;
  int             stub_cnt = 0, stub_k = 0;

  task automatic model_reset();
    q_lat = '{1'b1, 1'b1};
    q_ck  = '{1'b0, 1'b0, 1'b0};
    m_low = 0; m_idx = -1; m_late = 0; m_conv = 0; m_err = 0; m_data = '0;
  endtask

  task automatic model_edge(bit l, bit c, logic [WID-1:0] r);
    bit sl, crise, late_now, load, short_now;
    sl = q_lat.pop_front(); q_lat.push_back(l);
    crise = q_ck[1] && !q_ck[0];
    void'(q_ck.pop_front()); q_ck.push_back(c);
    late_now  = !sl && m_low < MINL && crise;
    load      = !sl && m_low == MINL - 1 && !m_late && !late_now;
    short_now = sl && m_low > 0 && m_low < MINL;
    if (sl) begin m_low = 0; m_late = 0; end
    else begin
      if (m_low < MINL) m_low++;
      if (late_now) m_late = 1;
    end
    if (short_now) m_err[0] = 1;
    if (late_now)  m_err[1] = 1;
    m_conv = load;
    if (load) begin m_data = r; m_idx = WID - 1; end
    else if (m_idx > 0) m_idx--;
  endtask

  task automatic check1(string what, logic [1:0] act, logic [1:0] exp);
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    logic exp_sdo;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      model_edge(latch_ni, conv_clk_i, result_i);
      exp_sdo = (m_idx >= 0) ? m_data[m_idx] : 1'b0;
      n_vec++;
      check1("sdo_o", {1'b0, sdo_o}, {1'b0, exp_sdo});
      check1("conv_o", {1'b0, conv_o}, {1'b0, m_conv});
      check1("err_o", err_o, m_err);
      if (stub_on) begin
        // stub core: new word appears a few cycles after its convert pulse
        if (conv_o) stub_cnt = 4;
        else if (stub_cnt > 0) begin
          stub_cnt--;
          if (stub_cnt == 0) begin
            stub_k++;
            result_i = WID'(stub_k * 16'h3B17 ^ 16'hC0DE);
          end
        end
      end
    end
  endtask

  task automatic strobe(int low_n, int gap_n);
    latch_ni = 1'b0; cyc(low_n);
    latch_ni = 1'b1; cyc(gap_n);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired, actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    tag = "R1";
    n_vec++; check1("sdo_o", {1'b0, sdo_o}, 2'b00);
    n_vec++; check1("conv_o", {1'b0, conv_o}, 2'b00);
    n_vec++; check1("err_o", err_o, 2'b00);
    rst_ni = 1'b1;

    tag = "R5";  result_i = 16'hA5C3; cyc(6);          // nothing captured yet
    tag = "R4";  strobe(2, 24);                         // R2 R3 R4 R5
    tag = "R10"; result_i = 16'h3C5A; strobe(12, 24);
    tag = "R6";  result_i = 16'h8001;
    latch_ni = 1'b0; cyc(2); latch_ni = 1'b1; cyc(4);
    result_i = 16'h7FFE; cyc(20);
    tag = "R11"; result_i = 16'hF00F; strobe(2, 6);
    result_i = 16'h0FF1; strobe(2, 24);
    tag = "R7";  result_i = 16'h1234; strobe(1, 24);
    tag = "R8";  result_i = 16'h5555;
    latch_ni = 1'b0; conv_clk_i = 1'b1; cyc(3);
    latch_ni = 1'b1; conv_clk_i = 1'b0; cyc(24);
    tag = "R9";  result_i = 16'hBEEF; strobe(2, 24);
    tag = "R7";  strobe(1, 8);
    // framed run: word n-1 shifts out while the stub converts word n
    tag = "R6"; stub_on = 1; result_i = 16'hCAFE;
    for (int f = 0; f < 8; f++) begin
      conv_clk_i = 1'b1; cyc(2);
      latch_ni = 1'b0;   cyc(2);
      latch_ni = 1'b1;   cyc(6);
      conv_clk_i = 1'b0; cyc(10);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule